// File: doc/BRIEF.md
# Dual-Port RAM with Write-Port Readback

This block is a synchronous word memory with one write port and one separate read address. It has two data outputs. The write-side output returns the word held at the write address. A parameter decides whether a write returns the word just written or the word it replaced. The read-side output returns the stored word at the read address. When the read address meets the write address in the same cycle, the read side always returns the stored word from before that write.

Two build-time variants reshape the block. In single-port mode the write address is also the read address, and the separate read address has no effect. A low write enable then simply reads. In asynchronous-read mode the output registers are removed. Both outputs then show the current memory contents in the same cycle, and the write-output policy no longer matters. The memory starts either with one fill word in every location or with a per-word table passed as a parameter. Reset clears only the output registers and never the stored words.

Top module: `wpr_dual_port_ram`

## Requirements
- R1: In synchronous mode, a clock edge with `rst_n` low drives both `wr_q` and `rd_q` to 0. Reset leaves the stored words unchanged, and a write presented while `rst_n` is low is not performed.
- R2: In synchronous mode, `rd_q` shows the stored word at `rd_addr` one clock after the address is presented.
- R3: When `wr_en` is high and `rd_addr` equals `wr_addr`, `rd_q` one clock later holds the word stored before that write, not `wr_data`.
- R4: With `WR_SHOW` = `WR_SHOW_NEW` (enum value 1) in synchronous mode, a write makes `wr_q` equal to `wr_data` one clock later.
- R5: With `WR_SHOW` = `WR_SHOW_OLD` (enum value 0) in synchronous mode, a write makes `wr_q` equal to the word held at `wr_addr` before the write, one clock later.
- R6: With `wr_en` low in synchronous mode, `wr_q` shows the stored word at `wr_addr` one clock later.
- R7: With `SINGLE_PORT` = 1, `rd_addr` has no effect. `rd_q` shows the word stored at `wr_addr` before any write in that cycle, and `wr_q` follows R4, R5 and R6.
- R8: With `ASYNC_RD` = 1, `wr_q` and `rd_q` show the current contents at `wr_addr` and `rd_addr` in the same cycle, whatever `WR_SHOW` is. A write becomes visible right after the clock edge that performs it.
- R9: With `USE_TABLE` = 0, every word starts as `INIT_FILL`. With `USE_TABLE` = 1, word i starts as `INIT_TABLE[i*DATA_W +: DATA_W]`.
- R10: The depth is 2**`ADDR_W` with `ADDR_W` from 2 to 31. The lowest and highest addresses hold distinct words with no aliasing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every write and output register uses its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output registers; also blocks writes |
| wr_en | input | 1 | Write enable; low means read at `wr_addr` |
| wr_addr | input | ADDR_W | Write address; the shared address in single-port mode |
| wr_data | input | DATA_W | Word to store |
| rd_addr | input | ADDR_W | Independent read address; unused in single-port mode |
| wr_q | output | DATA_W | Word at the write address, following the write-output policy |
| rd_q | output | DATA_W | Stored word at the read address, old data on collision |

## Verification
A wrong stored word shows up on `rd_q` the cycle after that address is read. It can stay hidden indefinitely unless the bench reads back every location it wrote. For that reason, both the lowest and the highest address are written and read back. A wrong policy or bypass path can make a collision cycle return `wr_data`. That error appears on the very next clock, so the bench checks collisions with new data that differs from the old word. A write that slips through during reset only shows up after reset, when the bench reads that location back.

// File: rtl/wpr_pkg.sv
// Package: shared types for the write-port-readback RAM.
// Assumes: nothing beyond IEEE 1800-2017.
package wpr_pkg;
    // Policy for the write-side output during a write cycle.
    typedef enum logic {
        WR_SHOW_OLD = 1'b0,
        WR_SHOW_NEW = 1'b1
    } wr_show_e;
endpackage

// File: rtl/wpr_store.sv
// Module: wpr_store
// Word storage with one write port and two combinational read taps.
// Assumes: write already qualified by the caller; contents set at start
// either from a fill word or from a per-word table; no reset of contents.
module wpr_store #(
    parameter int ADDR_W              = 4,
    parameter int DATA_W              = 16,
    parameter bit USE_TABLE           = 1'b0,
    parameter logic [DATA_W-1:0] INIT_FILL = '0,
    parameter logic [DATA_W*(2**ADDR_W)-1:0] INIT_TABLE = '0
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // Load starting contents from the fill word or the table.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            words[i] = USE_TABLE ? INIT_TABLE[i*DATA_W +: DATA_W] : INIT_FILL;
        end
    end

    // Store the qualified write.
    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    // Present both read taps from the current contents.
    always_comb begin
        rdata_a = words[raddr_a];
        rdata_b = words[raddr_b];
    end

    // R10
    write_lands_chk: assert property (@(posedge clk)
        we |=> words[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/wpr_out_reg.sv
// Module: wpr_out_reg
// One registered output of the RAM: picks the fresh word or the stored word.
// Assumes: synchronous-read build only; active-low synchronous reset.
module wpr_out_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_new,
    input  logic [DATA_W-1:0] new_word,
    input  logic [DATA_W-1:0] old_word,
    output logic [DATA_W-1:0] q
);
    // Register the chosen word, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= take_new ? new_word : old_word;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> q == '0);
endmodule

// File: rtl/wpr_dual_port_ram.sv
// Module: wpr_dual_port_ram
// RAM with one write port, an independent read address and a readback
// output on the write side. Variants: single shared address, asynchronous
// read, new-data or old-data write output.
// Assumes: single clock; ADDR_W in 2..31; reset touches only output registers.
module wpr_dual_port_ram
    import wpr_pkg::*;
#(
    parameter int       ADDR_W      = 4,
    parameter int       DATA_W      = 16,
    parameter bit       SINGLE_PORT = 1'b0,
    parameter bit       ASYNC_RD    = 1'b0,
    parameter wr_show_e WR_SHOW     = WR_SHOW_NEW,
    parameter bit       USE_TABLE   = 1'b0,
    parameter logic [DATA_W-1:0] INIT_FILL = '0,
    parameter logic [DATA_W*(2**ADDR_W)-1:0] INIT_TABLE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] wr_q,
    output logic [DATA_W-1:0] rd_q
);
    localparam bit SHOW_NEW = (WR_SHOW == WR_SHOW_NEW);

    if (ADDR_W < 2 || ADDR_W > 31) begin : g_bad_width
        $error("wpr_dual_port_ram: ADDR_W must lie in 2..31");
    end

    logic              store_we;
    logic [ADDR_W-1:0] rd_sel;
    logic [DATA_W-1:0] wr_word;
    logic [DATA_W-1:0] rd_word;

    // Qualify writes with reset and pick the read address per mode.
    always_comb begin
        store_we = wr_en && rst_n;
        rd_sel   = SINGLE_PORT ? wr_addr : rd_addr;
    end

    wpr_store #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .USE_TABLE  (USE_TABLE),
        .INIT_FILL  (INIT_FILL),
        .INIT_TABLE (INIT_TABLE)
    ) u_store (
        .clk     (clk),
        .we      (store_we),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .raddr_a (wr_addr),
        .raddr_b (rd_sel),
        .rdata_a (wr_word),
        .rdata_b (rd_word)
    );

    if (ASYNC_RD) begin : g_async
        // Same-cycle view of current contents; policy does not apply.
        always_comb begin
            wr_q = wr_word;
            rd_q = rd_word;
        end
    end else begin : g_sync
        wpr_out_reg #(.DATA_W(DATA_W)) u_wr_out (
            .clk      (clk),
            .rst_n    (rst_n),
            .take_new (store_we && SHOW_NEW),
            .new_word (wr_data),
            .old_word (wr_word),
            .q        (wr_q)
        );

        wpr_out_reg #(.DATA_W(DATA_W)) u_rd_out (
            .clk      (clk),
            .rst_n    (rst_n),
            .take_new (1'b0),
            .new_word (wr_data),
            .old_word (rd_word),
            .q        (rd_q)
        );

        // R3
        collide_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && rd_sel == wr_addr && wr_data != rd_word)
            |=> rd_q != $past(wr_data));

        if (SHOW_NEW) begin : g_new_chk
            // R4
            wr_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> wr_q == $past(wr_data));
        end else begin : g_old_chk
            // R5
            wr_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_data != wr_word) |=> wr_q != $past(wr_data));
        end
    end
endmodule

// File: tb/wpr_dual_port_ram_tb.sv
module wpr_dual_port_ram_tb;
    import wpr_pkg::*;

    localparam int AW = 4;
    localparam int DW = 16;
    localparam int DEPTH = 2 ** AW;

    function automatic logic [DW*DEPTH-1:0] build_table();
        logic [DW*DEPTH-1:0] t;
        for (int i = 0; i < DEPTH; i++) t[i*DW +: DW] = 16'h1000 + 16'(i);
        return t;
    endfunction
    localparam logic [DW*DEPTH-1:0] TABLE = build_table();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // main: two-port, synchronous, new-data policy, fill init
    logic          a_en = 1'b0;
    logic [AW-1:0] a_wa = '0, a_ra = '0;
    logic [DW-1:0] a_wd = '0, a_wq, a_rq;
    // single-port, old-data policy, table init
    logic          b_en = 1'b0;
    logic [AW-1:0] b_wa = '0, b_ra = '0;
    logic [DW-1:0] b_wd = '0, b_wq, b_rq;
    // asynchronous read
    logic          c_en = 1'b0;
    logic [AW-1:0] c_wa = '0, c_ra = '0;
    logic [DW-1:0] c_wd = '0, c_wq, c_rq;

    wpr_dual_port_ram #(.ADDR_W(AW), .DATA_W(DW), .SINGLE_PORT(1'b0),
        .ASYNC_RD(1'b0), .WR_SHOW(WR_SHOW_NEW), .USE_TABLE(1'b0),
        .INIT_FILL(16'h00A5)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(a_en), .wr_addr(a_wa),
        .wr_data(a_wd), .rd_addr(a_ra), .wr_q(a_wq), .rd_q(a_rq));

    wpr_dual_port_ram #(.ADDR_W(AW), .DATA_W(DW), .SINGLE_PORT(1'b1),
        .ASYNC_RD(1'b0), .WR_SHOW(WR_SHOW_OLD), .USE_TABLE(1'b1),
        .INIT_TABLE(TABLE)) u_dut_sp (
        .clk(clk), .rst_n(rst_n), .wr_en(b_en), .wr_addr(b_wa),
        .wr_data(b_wd), .rd_addr(b_ra), .wr_q(b_wq), .rd_q(b_rq));

    wpr_dual_port_ram #(.ADDR_W(AW), .DATA_W(DW), .SINGLE_PORT(1'b0),
        .ASYNC_RD(1'b1), .WR_SHOW(WR_SHOW_NEW), .USE_TABLE(1'b0),
        .INIT_FILL(16'h0000)) u_dut_as (
        .clk(clk), .rst_n(rst_n), .wr_en(c_en), .wr_addr(c_wa),
        .wr_data(c_wd), .rd_addr(c_ra), .wr_q(c_wq), .rd_q(c_rq));

    task automatic chk(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive main port at a falling edge, then wait one clock.
    task automatic a_cycle(input logic en, input logic [AW-1:0] wa,
                           input logic [DW-1:0] wd, input logic [AW-1:0] ra);
        a_en = en; a_wa = wa; a_wd = wd; a_ra = ra;
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 wr_q in reset", a_wq, '0);
        chk("R1 rd_q in reset", a_rq, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_init();
        a_cycle(1'b0, 4'd0, '0, 4'd0);
        chk("R9 fill word addr0", a_rq, 16'h00A5);
        a_cycle(1'b0, 4'd15, '0, 4'd15);
        chk("R2 fill word addr15", a_rq, 16'h00A5);
        b_en = 1'b0; b_wa = 4'd7; b_ra = 4'd2;
        @(negedge clk);
        chk("R9 table word 7 on wr_q", b_wq, 16'h1007);
        chk("R7 rd_q follows shared addr", b_rq, 16'h1007);
    endtask

    task automatic t_write_new();
        a_cycle(1'b1, 4'd3, 16'h1234, 4'd3);
        chk("R4 new data on wr_q", a_wq, 16'h1234);
        chk("R3 collision returns old", a_rq, 16'h00A5);
        a_cycle(1'b0, 4'd3, 16'hDEAD, 4'd3);
        chk("R6 idle wr_q shows contents", a_wq, 16'h1234);
        chk("R2 read after write", a_rq, 16'h1234);
    endtask

    task automatic t_edges();
        a_cycle(1'b1, 4'd15, 16'hBEEF, 4'd1);
        a_cycle(1'b1, 4'd0, 16'h0001, 4'd2);
        a_cycle(1'b0, 4'd0, '0, 4'd15);
        chk("R10 top address kept", a_rq, 16'hBEEF);
        chk("R10 low address kept", a_wq, 16'h0001);
    endtask

    task automatic t_reset_keep();
        rst_n = 1'b0;
        a_cycle(1'b1, 4'd3, 16'hFFFF, 4'd3);
        a_cycle(1'b1, 4'd3, 16'hFFFF, 4'd3);
        chk("R1 wr_q cleared", a_wq, '0);
        chk("R1 rd_q cleared", a_rq, '0);
        rst_n = 1'b1;
        a_cycle(1'b0, 4'd0, '0, 4'd3);
        chk("R1 contents kept, write blocked", a_rq, 16'h1234);
    endtask

    task automatic t_old();
        b_en = 1'b1; b_wa = 4'd7; b_wd = 16'h7777; b_ra = 4'd2;
        @(negedge clk);
        chk("R5 old data on wr_q", b_wq, 16'h1007);
        chk("R7 rd_addr ignored", b_rq, 16'h1007);
        b_en = 1'b0; b_wa = 4'd7; b_ra = 4'd9;
        @(negedge clk);
        chk("R6 single-port read back", b_wq, 16'h7777);
        chk("R7 rd_q at shared addr", b_rq, 16'h7777);
    endtask

    task automatic t_async();
        c_en = 1'b1; c_wa = 4'd5; c_ra = 4'd5; c_wd = 16'h4242;
        #1;
        chk("R8 same-cycle wr_q old", c_wq, 16'h0000);
        chk("R8 same-cycle rd_q old", c_rq, 16'h0000);
        @(posedge clk);
        #1;
        chk("R8 wr_q after edge", c_wq, 16'h4242);
        chk("R8 rd_q after edge", c_rq, 16'h4242);
        @(negedge clk);
        c_en = 1'b0; c_ra = 4'd6;
        #1;
        chk("R8 rd_q other addr", c_rq, 16'h0000);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_init();
        t_write_new();
        t_edges();
        t_reset_keep();
        t_old();
        t_async();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule